// File: doc/BRIEF.md
# Byte-Lane Pseudo-SRAM Mode Decoder

This block is a clocked, synthesizable model of a 16-bit-wide memory that sits behind an SRAM-style control interface. On every clock edge it samples two chip enables of opposite polarity, a write strobe, an output strobe and one active-low enable per byte lane. From these it works out one operating mode: power down, standby, output disable, read or write. Writes update only the byte lanes whose enable is low. Reads drive only those lanes, and the data bus is released everywhere else. The full part has 20 address bits, which gives 1,048,576 words. `ADDR_W` shrinks the array so that simulation stays small.

The active-high chip enable takes priority over every other input. While it is low, the block is powered down: nothing is written, no lane is driven, and every stored byte is marked as lost. Each byte lane of each word carries its own validity bit. A lost lane reads back as zero, and the stale indicator rises until that lane is written again. Standby and output disable both keep the stored contents.

Results are registered. Mode, lane output enables, read data and the stale indicator all reflect the inputs sampled at the previous rising clock edge.

Top module: `bytelane_psram`

## Requirements
- R1: After reset, `mode` reads 1 (standby), `dq_oe` and `dq_out` are zero, `rd_stale` is 0, and every byte lane of every word is invalid.
- R2: The mode is decided in this order, first match wins. When `ce_on`=0 the mode is 0 (power down). When `ce_n`=1 it is 1 (standby). When `we_n`=0 it is 4 (write). When `oe_n`=0 it is 3 (read). Otherwise it is 2 (output disable). The `mode` output shows the code one cycle after the inputs are sampled.
- R3: In power down, `dq_oe` is 0 whatever the other inputs are, and no write takes place.
- R4: In standby and in output disable, `dq_oe` is 0. A lane whose `dq_oe` bit is 0 shows zero on its byte of `dq_out`.
- R5: In a read, `dq_oe[i]` equals the inverse of `be_n[i]`. Lane 0 is `dq_out[7:0]` and lane 1 is `dq_out[15:8]`. A driven, valid lane shows the stored byte.
- R6: In a write, only the lanes with `be_n[i]`=0 take the matching byte of `dq_in`. The byte of the other lane is ignored, and the stored byte there keeps its value.
- R7: A write with every `be_n` bit at 1 changes no stored byte.
- R8: When `we_n`=0 and `oe_n`=0 with the chip selected, the block writes and `dq_oe` stays 0.
- R9: Power down marks every lane of every word invalid. A driven lane that is invalid reads as zero and sets `rd_stale`=1. Standby keeps both the data and the validity.
- R10: Writing a lane makes that lane valid again, while the lanes that were not written stay invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Word address |
| ce_on | input | 1 | Active-high chip enable; low selects power down |
| ce_n | input | 1 | Active-low chip enable |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output strobe |
| be_n | input | LANES | Active-low byte-lane enables, bit 0 the lower byte |
| dq_in | input | LANES*LANE_W | Write data |
| dq_out | output | LANES*LANE_W | Read data, zero on undriven lanes |
| dq_oe | output | LANES | Per-lane output enable for the data pads |
| mode | output | 3 | Mode code of the previous sample |
| rd_stale | output | 1 | A driven lane of the last read held lost data |

## Verification
A wrong validity bit shows up on the very next read of that word. The read either returns zero with `rd_stale` set where a stored byte was expected, or it returns a stale byte with no flag. A lane enable that is decoded wrongly shows one cycle after the sample, either as a `dq_oe` bit driving during a write or power down, or as the neighbouring lane's byte changing. A mode error appears on `mode` in the next cycle. Because the bench models the memory independently, a lost write is caught at the first read-back of that address.

// File: rtl/bytelane_psram_pkg.sv
package bytelane_psram_pkg;

    typedef enum logic [2:0] {
        MODE_PWRDN = 3'd0,
        MODE_STBY  = 3'd1,
        MODE_ODIS  = 3'd2,
        MODE_READ  = 3'd3,
        MODE_WRITE = 3'd4
    } psram_mode_e;

endpackage

// File: rtl/bytelane_psram_decode.sv
module bytelane_psram_decode
    import bytelane_psram_pkg::*;
(
    input  logic        ce_on,
    input  logic        ce_n,
    input  logic        we_n,
    input  logic        oe_n,
    output psram_mode_e mode
);

    // Priority: power-down enable, then chip select, then write, then read.
    always_comb begin
        if (!ce_on) begin
            mode = MODE_PWRDN;
        end else if (ce_n) begin
            mode = MODE_STBY;
        end else if (!we_n) begin
            mode = MODE_WRITE;
        end else if (!oe_n) begin
            mode = MODE_READ;
        end else begin
            mode = MODE_ODIS;
        end
    end

endmodule

// File: rtl/bytelane_psram_lane.sv
module bytelane_psram_lane
    import bytelane_psram_pkg::*;
#(
    parameter int LANES = 2
) (
    input  psram_mode_e      mode,
    input  logic [LANES-1:0] be_n,
    output logic [LANES-1:0] wr_en,
    output logic [LANES-1:0] rd_en
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign wr_en[g] = (mode == MODE_WRITE) && !be_n[g];
        assign rd_en[g] = (mode == MODE_READ)  && !be_n[g];
    end

endmodule

// File: rtl/bytelane_psram_store.sv
module bytelane_psram_store #(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 8,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    pd,
    input  logic [LANES-1:0]        wr_en,
    input  logic [LANES*LANE_W-1:0] wr_data,
    output logic [LANES*LANE_W-1:0] rd_data,
    output logic [LANES-1:0]        rd_ok
);

    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [DEPTH-1:0][LANES-1:0] valid;
    } store_t;

    store_t st_d, st_q;

    // Power down wipes all validity; a lane write restores that lane only.
    always_comb begin
        st_d = st_q;
        if (pd) begin
            st_d.valid = '0;
        end else begin
            for (int l = 0; l < LANES; l++) begin
                if (wr_en[l]) begin
                    st_d.valid[addr][l] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_bank
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en[g]) begin
                cells[addr] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = cells[addr];
        assign rd_ok[g]                    = st_q.valid[addr][g];
    end

endmodule

// File: rtl/bytelane_psram.sv
module bytelane_psram
    import bytelane_psram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 8,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    ce_on,
    input  logic                    ce_n,
    input  logic                    we_n,
    input  logic                    oe_n,
    input  logic [LANES-1:0]        be_n,
    input  logic [LANES*LANE_W-1:0] dq_in,
    output logic [LANES*LANE_W-1:0] dq_out,
    output logic [LANES-1:0]        dq_oe,
    output logic [2:0]              mode,
    output logic                    rd_stale
);

    localparam int DW = LANES * LANE_W;

    typedef struct packed {
        psram_mode_e      mode;
        logic [LANES-1:0] oe;
        logic [DW-1:0]    data;
        logic             stale;
    } out_t;

    psram_mode_e      cur_mode;
    logic [LANES-1:0] wr_en;
    logic [LANES-1:0] rd_en;
    logic [LANES-1:0] rd_ok;
    logic [DW-1:0]    rd_data;
    out_t             out_d, out_q;

    bytelane_psram_decode u_decode (
        .ce_on (ce_on),
        .ce_n  (ce_n),
        .we_n  (we_n),
        .oe_n  (oe_n),
        .mode  (cur_mode)
    );

    bytelane_psram_lane #(.LANES(LANES)) u_lane (
        .mode  (cur_mode),
        .be_n  (be_n),
        .wr_en (wr_en),
        .rd_en (rd_en)
    );

    bytelane_psram_store #(
        .ADDR_W (ADDR_W),
        .LANE_W (LANE_W),
        .LANES  (LANES)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .pd      (cur_mode == MODE_PWRDN),
        .wr_en   (wr_en),
        .wr_data (dq_in),
        .rd_data (rd_data),
        .rd_ok   (rd_ok)
    );

    always_comb begin
        out_d.mode  = cur_mode;
        out_d.oe    = rd_en;
        out_d.stale = |(rd_en & ~rd_ok);
        for (int l = 0; l < LANES; l++) begin
            out_d.data[l*LANE_W +: LANE_W] =
                (rd_en[l] && rd_ok[l]) ? rd_data[l*LANE_W +: LANE_W] : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q.mode  <= MODE_STBY;
            out_q.oe    <= '0;
            out_q.data  <= '0;
            out_q.stale <= 1'b0;
        end else begin
            out_q <= out_d;
        end
    end

    assign mode     = out_q.mode;
    assign dq_oe    = out_q.oe;
    assign dq_out   = out_q.data;
    assign rd_stale = out_q.stale;

endmodule

// File: rtl/bytelane_psram_chk.sv
module bytelane_psram_chk #(
    parameter int LANE_W = 8,
    parameter int LANES  = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    ce_on,
    input logic                    ce_n,
    input logic                    we_n,
    input logic                    oe_n,
    input logic [LANES-1:0]        be_n,
    input logic [LANES*LANE_W-1:0] dq_out,
    input logic [LANES-1:0]        dq_oe,
    input logic [2:0]              mode,
    input logic                    rd_stale
);

    assert_pd_float_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_on |=> (dq_oe == '0 && mode == 3'd0));

    assert_standby_float_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_on && ce_n) |=> (dq_oe == '0 && mode == 3'd1));

    assert_quiet_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe == '0) |-> (dq_out == '0));

    assert_read_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_on && !ce_n && we_n && !oe_n) |=> (dq_oe == ~$past(be_n)));

    assert_write_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_on && !ce_n && !we_n) |=> (dq_oe == '0 && mode == 3'd4));

    assert_stale_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stale |-> (dq_oe != '0));

endmodule

bind bytelane_psram bytelane_psram_chk #(
    .LANE_W (LANE_W),
    .LANES  (LANES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_on    (ce_on),
    .ce_n     (ce_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .be_n     (be_n),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe),
    .mode     (mode),
    .rd_stale (rd_stale)
);

// File: tb/bytelane_psram_bench.sv
module bytelane_psram_bench;

    localparam int ADDR_W = 8;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              ce_on = 1'b1, ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [1:0]        be_n = 2'b11;
    logic [15:0]       dq_in = '0;
    logic [15:0]       dq_out;
    logic [1:0]        dq_oe;
    logic [2:0]        mode;
    logic              rd_stale;

    always #10 clk = ~clk;

    bytelane_psram #(.ADDR_W(ADDR_W), .LANE_W(8), .LANES(2)) u_bytelane_psram (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_on(ce_on), .ce_n(ce_n),
        .we_n(we_n), .oe_n(oe_n), .be_n(be_n), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe), .mode(mode), .rd_stale(rd_stale)
    );

    typedef struct {
        logic [2:0]  mode;
        logic [1:0]  oe;
        logic [15:0] data;
        logic        stale;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;
    logic [15:0] ref_mem [DEPTH];
    logic [1:0]  ref_val [DEPTH];

    task automatic check(input bit ok, input string tag, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s", tag, what);
        end
    endtask

    // Driver: predicts the result from the requirements and updates the model.
    task automatic apply(input logic on, input logic cn, input logic wn, input logic on_oe,
                         input logic [1:0] ben, input logic [ADDR_W-1:0] a,
                         input logic [15:0] d, input string tag);
        exp_t e;
        @(negedge clk);
        ce_on = on; ce_n = cn; we_n = wn; oe_n = on_oe; be_n = ben; addr = a; dq_in = d;
        e.tag = tag; e.oe = 2'b00; e.data = '0; e.stale = 1'b0;
        if (!on)           e.mode = 3'd0;
        else if (cn)       e.mode = 3'd1;
        else if (!wn)      e.mode = 3'd4;
        else if (!on_oe)   e.mode = 3'd3;
        else               e.mode = 3'd2;
        if (e.mode == 3'd3) begin
            e.oe = ~ben;
            for (int l = 0; l < 2; l++) begin
                if (e.oe[l]) begin
                    if (ref_val[a][l]) e.data[l*8 +: 8] = ref_mem[a][l*8 +: 8];
                    else               e.stale = 1'b1;
                end
            end
        end
        if (e.mode == 3'd4) begin
            for (int l = 0; l < 2; l++) begin
                if (!ben[l]) begin
                    ref_mem[a][l*8 +: 8] = d[l*8 +: 8];
                    ref_val[a][l] = 1'b1;
                end
            end
        end
        if (e.mode == 3'd0) begin
            for (int i = 0; i < DEPTH; i++) ref_val[i] = 2'b00;
        end
        sb.push_back(e);
    endtask

    // Monitor: result of a sample appears after the next rising edge.
    always @(posedge clk) begin
        #1;
        if (rst_n && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(mode == e.mode && dq_oe == e.oe && dq_out == e.data && rd_stale == e.stale,
                  e.tag,
                  $sformatf("actual mode=%0d oe=%b data=%h stale=%b expected mode=%0d oe=%b data=%h stale=%b",
                            mode, dq_oe, dq_out, rd_stale, e.mode, e.oe, e.data, e.stale));
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            ref_val[i] = 2'b00;
            ref_mem[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1;
        check(mode == 3'd1 && dq_oe == 2'b00 && dq_out == 16'h0 && rd_stale == 1'b0, "R1",
              $sformatf("reset actual mode=%0d oe=%b data=%h stale=%b expected 1 00 0000 0",
                        mode, dq_oe, dq_out, rd_stale));
        @(negedge clk);
        rst_n = 1'b1;

        apply(1, 0, 1, 0, 2'b00, 8'd3, 16'h0, "R1 invalid after reset");
        apply(1, 0, 0, 1, 2'b00, 8'd3, 16'hA5C3, "R6 word write");
        apply(1, 0, 1, 0, 2'b00, 8'd3, 16'h0, "R5 word read");
        apply(1, 0, 0, 1, 2'b10, 8'd3, 16'h1177, "R6 lower write");
        apply(1, 0, 1, 0, 2'b01, 8'd3, 16'h0, "R5 upper read");
        apply(1, 0, 1, 0, 2'b10, 8'd3, 16'h0, "R6 lower read");
        apply(1, 0, 0, 1, 2'b11, 8'd3, 16'hFFFF, "R7 masked write");
        apply(1, 0, 1, 0, 2'b00, 8'd3, 16'h0, "R7 read after masked");
        apply(1, 0, 0, 0, 2'b00, 8'd4, 16'h1234, "R8 write with oe low");
        apply(1, 0, 1, 0, 2'b00, 8'd4, 16'h0, "R8 read back");
        apply(1, 1, 1, 0, 2'b00, 8'd3, 16'h0, "R4 standby");
        apply(1, 0, 1, 1, 2'b00, 8'd3, 16'h0, "R4 output disable");
        apply(1, 0, 1, 0, 2'b00, 8'd3, 16'h0, "R9 retained after standby");
        apply(1, 0, 1, 0, 2'b11, 8'd3, 16'h0, "R5 read no lanes");
        apply(0, 0, 0, 0, 2'b00, 8'd4, 16'hBEEF, "R3 power down");
        apply(0, 1, 1, 0, 2'b00, 8'd3, 16'h0, "R2 power down priority");
        apply(1, 0, 1, 0, 2'b00, 8'd4, 16'h0, "R9 lost after power down");
        apply(1, 0, 1, 0, 2'b00, 8'd3, 16'h0, "R9 lost word 3");
        apply(1, 0, 0, 1, 2'b10, 8'd3, 16'h55EE, "R10 lower rewrite");
        apply(1, 0, 1, 0, 2'b00, 8'd3, 16'h0, "R10 partial valid");
        apply(1, 0, 0, 1, 2'b01, 8'd3, 16'h6600, "R10 upper rewrite");
        apply(1, 0, 1, 0, 2'b00, 8'd3, 16'h0, "R10 fully valid");
        for (int i = 0; i < 6; i++) begin
            logic [ADDR_W-1:0] a;
            a = (i == 0) ? '0 : (i == 5) ? '1 : ADDR_W'(i * 37);
            apply(1, 0, 0, 1, 2'b00, a, 16'(16'h1F2E * (i + 1)), "R6 sweep write");
        end
        for (int i = 0; i < 6; i++) begin
            logic [ADDR_W-1:0] a;
            a = (i == 0) ? '0 : (i == 5) ? '1 : ADDR_W'(i * 37);
            apply(1, 0, 1, 0, 2'(i % 3), a, 16'h0, "R5 sweep read");
        end
        apply(1, 1, 1, 1, 2'b11, 8'd0, 16'h0, "R2 idle");
        while (sb.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule